// File: doc/BRIEF.md
# Base Address Region Decoder

This block turns the address-map registers of one configuration header into a decoded map of address windows. It takes the command register, six standard region registers and one expansion-ROM register. For every region it works out the aligned base and whether the region is currently mapped. Region sizes, the address space of each region (I/O or memory) and whether a region exists at all are fixed by parameters. All region sizes are powers of two.

The block then looks up an incoming transaction address, tagged as I/O or memory, against the mapped regions. It reports whether a region was hit and which one. The per-region flags and bases are combinational in the register inputs. The lookup result is registered and appears one clock after the request. Moving the data of the transaction is left to the surrounding logic.

Top module: `bar_region_decoder`

## Requirements
- R1: An I/O region can be valid only while command bit 0 (I/O space enable) is set. A memory region, including the ROM region, can be valid only while command bit 1 (memory space enable) is set.
- R2: Each region's reported base is its register value with the low log2(size) bits cleared. The region spans base to base + size - 1. Region i is reported at `regionBase[i*ADDR_W +: ADDR_W]`, and the ROM region is index 6.
- R3: An I/O region is invalid when its base is zero, when its end is not above its base, or when its end is at or above 0x10000.
- R4: A memory region is invalid when its base is zero, when its end is not above its base, or when its end equals all ones.
- R5: The ROM region is always a memory region. It is valid only when bit 0 of its own register is set, in addition to the memory enable.
- R6: A region configured as absent (size zero) is never valid and is never hit.
- R7: A request with `reqValid` high hits region i when region i is valid, its space matches `reqIsIo`, and base <= `reqAddr` <= end. `hitValid` and `hitIndex` show the result one clock after the request.
- R8: When several regions are hit, the lowest-numbered region is reported.
- R9: A cycle without a request, or a request that hits nothing, gives `hitValid` = 0 and `hitIndex` = 0 on the following clock.
- R10: While `rstN` is low, `hitValid` and `hitIndex` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdReg | input | 16 | Command register; bit 0 enables I/O space, bit 1 enables memory space |
| barRegs | input | NUM_STD*ADDR_W | Standard region registers, region i in slice i |
| romReg | input | ADDR_W | Expansion-ROM register; bit 0 is its enable |
| reqValid | input | 1 | Lookup request present |
| reqIsIo | input | 1 | 1 for an I/O request, 0 for a memory request |
| reqAddr | input | ADDR_W | Request address |
| regionValid | output | NUM_STD+1 | Per-region mapped flag |
| regionBase | output | (NUM_STD+1)*ADDR_W | Per-region aligned base |
| hitValid | output | 1 | Registered hit flag |
| hitIndex | output | IDX_W | Registered index of the winning region |

## Verification
The command register is stepped through all four enable combinations over one fixed map, and the expected valid vector separates I/O gating from memory gating. Register values are then placed at the edges of each rejection rule: zero base, an I/O end exactly at 0xFFFF and one past it, and a memory end at all ones and one region below it. These show which boundary each rule uses. Lookups probe the first and last byte of a region and the bytes just outside it, send requests with the wrong space, and stack overlapping regions, including the ROM, to check that the lowest index wins. Address patterns that would hit but arrive without `reqValid` show that an idle cycle gives no hit.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;

  // Command register bit positions (standard header layout).
  localparam int CMD_IO_BIT  = 0;
  localparam int CMD_MEM_BIT = 1;
  // Enable bit inside the expansion-ROM register.
  localparam int ROM_EN_BIT  = 0;
  // Width of one log2-size field in the size parameter.
  localparam int LOG2_W      = 6;

  // Strobes from control to datapath.
  typedef struct packed {
    logic ioSpaceOn;   // I/O regions may be mapped
    logic memSpaceOn;  // standard memory regions may be mapped
    logic romOn;       // ROM region may be mapped
    logic lookIo;      // I/O lookup this cycle
    logic lookMem;     // memory lookup this cycle
  } decStrobes_t;

endpackage

// File: rtl/bar_dec_ctrl.sv
module bar_dec_ctrl
  import bar_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cmdReg,
  input  logic        romEnBit,
  input  logic        reqValid,
  input  logic        reqIsIo,
  output decStrobes_t strobes
);

  always_comb begin
    strobes.ioSpaceOn  = cmdReg[CMD_IO_BIT];
    strobes.memSpaceOn = cmdReg[CMD_MEM_BIT];
    strobes.romOn      = cmdReg[CMD_MEM_BIT] & romEnBit;
    strobes.lookIo     = reqValid & reqIsIo;
    strobes.lookMem    = reqValid & ~reqIsIo;
  end

  // R7: a lookup strobe names exactly one space, never both
  p_one_space_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.lookIo, strobes.lookMem}));

  // R5: the ROM strobe never runs ahead of the memory strobe
  p_rom_under_mem_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.romOn |-> strobes.memSpaceOn);

endmodule

// File: rtl/bar_dec_datapath.sv
module bar_dec_datapath
  import bar_dec_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_STD = 6,
  parameter int NUM_REG = NUM_STD + 1,
  parameter int IDX_W   = $clog2(NUM_REG),
  parameter logic [NUM_REG-1:0]        REGION_PRESENT = '1,
  parameter logic [NUM_REG-1:0]        REGION_IS_IO   = '0,
  parameter logic [NUM_REG*LOG2_W-1:0] REGION_LOG2    = '0,
  parameter logic [ADDR_W-1:0]         IO_SPACE_TOP   = ADDR_W'(32'h0001_0000)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  decStrobes_t               strobes,
  input  logic [NUM_STD*ADDR_W-1:0] barRegs,
  input  logic [ADDR_W-1:0]         romReg,
  input  logic [ADDR_W-1:0]         reqAddr,
  output logic [NUM_REG-1:0]        regionValid,
  output logic [NUM_REG*ADDR_W-1:0] regionBase,
  output logic                      hitValid,
  output logic [IDX_W-1:0]          hitIndex
);

  logic [NUM_REG-1:0] matchVec;
  logic [NUM_REG-1:0] ioKind;
  logic [IDX_W-1:0]   firstIdx;
  logic               anyMatch;

  for (genvar gi = 0; gi < NUM_REG; gi++) begin : g_region
    localparam int                 LG    = int'(REGION_LOG2[gi*LOG2_W +: LOG2_W]);
    localparam logic [ADDR_W-1:0]  MASK  = (ADDR_W'(1) << LG) - ADDR_W'(1);
    localparam bit                 IS_IO = (gi < NUM_STD) && REGION_IS_IO[gi];

    logic [ADDR_W-1:0] rawVal;
    logic [ADDR_W-1:0] regBase;
    logic [ADDR_W-1:0] regEnd;
    logic              badPlace;
    logic              spaceOn;

    if (gi < NUM_STD) begin : g_std
      assign rawVal  = barRegs[gi*ADDR_W +: ADDR_W];
      assign spaceOn = IS_IO ? strobes.ioSpaceOn : strobes.memSpaceOn;
    end else begin : g_rom
      assign rawVal  = romReg;
      assign spaceOn = strobes.romOn;
    end

    assign regBase = rawVal & ~MASK;
    assign regEnd  = regBase + MASK;

    if (IS_IO) begin : g_io_rule
      assign badPlace = (regEnd <= regBase) || (regBase == '0) ||
                        (regEnd >= IO_SPACE_TOP);
    end else begin : g_mem_rule
      assign badPlace = (regEnd <= regBase) || (regBase == '0) ||
                        (regEnd == '1);
    end

    assign ioKind[gi]      = IS_IO;
    assign regionValid[gi] = REGION_PRESENT[gi] && spaceOn && !badPlace;
    assign regionBase[gi*ADDR_W +: ADDR_W] = regBase;
    assign matchVec[gi] = regionValid[gi] &&
                          (IS_IO ? strobes.lookIo : strobes.lookMem) &&
                          (reqAddr >= regBase) && (reqAddr <= regEnd);

    // R6: an absent region never reports itself mapped
    if (!REGION_PRESENT[gi]) begin : g_absent_chk
      p_absent_never_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
        !regionValid[gi]);
    end
  end

  assign anyMatch = |matchVec;

  always_comb begin
    firstIdx = '0;
    for (int i = NUM_REG - 1; i >= 0; i--) begin
      if (matchVec[i]) firstIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitValid <= 1'b0;
      hitIndex <= '0;
    end else begin
      hitValid <= anyMatch;
      hitIndex <= firstIdx;
    end
  end

  // R1: no I/O region mapped while I/O space is off
  p_io_needs_enable_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.ioSpaceOn |-> ((regionValid & ioKind) == '0));

  // R1: no memory region mapped while memory space is off
  p_mem_needs_enable_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.memSpaceOn |-> ((regionValid & ~ioKind) == '0));

  // R7: a reported hit names a region that was valid at request time
  p_hit_was_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> |($past(regionValid) & (NUM_REG'(1) << hitIndex)));

  // R9: an idle cycle yields no hit and index zero
  p_idle_no_hit_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.lookIo | strobes.lookMem) |-> (!hitValid && hitIndex == '0));

  // R8: the winning index is always a real region
  p_index_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> (int'(hitIndex) < NUM_REG));

endmodule

// File: rtl/bar_region_decoder.sv
module bar_region_decoder
  import bar_dec_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_STD = 6,
  parameter int NUM_REG = NUM_STD + 1,
  parameter int IDX_W   = $clog2(NUM_REG),
  // Region 6 is the ROM; bit order is region index.
  parameter logic [NUM_REG-1:0]        REGION_PRESENT = 7'b110_1111,
  parameter logic [NUM_REG-1:0]        REGION_IS_IO   = 7'b000_1001,
  parameter logic [NUM_REG*LOG2_W-1:0] REGION_LOG2    =
    {6'd16, 6'd4, 6'd12, 6'd8, 6'd20, 6'd12, 6'd4},
  parameter logic [ADDR_W-1:0]         IO_SPACE_TOP   = ADDR_W'(32'h0001_0000)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [15:0]               cmdReg,
  input  logic [NUM_STD*ADDR_W-1:0] barRegs,
  input  logic [ADDR_W-1:0]         romReg,
  input  logic                      reqValid,
  input  logic                      reqIsIo,
  input  logic [ADDR_W-1:0]         reqAddr,
  output logic [NUM_REG-1:0]        regionValid,
  output logic [NUM_REG*ADDR_W-1:0] regionBase,
  output logic                      hitValid,
  output logic [IDX_W-1:0]          hitIndex
);

  decStrobes_t strobes;

  bar_dec_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdReg   (cmdReg),
    .romEnBit (romReg[ROM_EN_BIT]),
    .reqValid (reqValid),
    .reqIsIo  (reqIsIo),
    .strobes  (strobes)
  );

  bar_dec_datapath #(
    .ADDR_W         (ADDR_W),
    .NUM_STD        (NUM_STD),
    .NUM_REG        (NUM_REG),
    .IDX_W          (IDX_W),
    .REGION_PRESENT (REGION_PRESENT),
    .REGION_IS_IO   (REGION_IS_IO),
    .REGION_LOG2    (REGION_LOG2),
    .IO_SPACE_TOP   (IO_SPACE_TOP)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .barRegs     (barRegs),
    .romReg      (romReg),
    .reqAddr     (reqAddr),
    .regionValid (regionValid),
    .regionBase  (regionBase),
    .hitValid    (hitValid),
    .hitIndex    (hitIndex)
  );

  // R5: ROM mapped only with its own enable and memory space on
  p_rom_enable_r5: assert property (@(posedge clk) disable iff (!rstN)
    regionValid[NUM_STD] |-> (romReg[ROM_EN_BIT] && cmdReg[CMD_MEM_BIT]));

endmodule

// File: tb/test_bar_region_decoder.sv
module test_bar_region_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NS = 6;
  localparam int NR = 7;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [15:0]    cmdReg = '0;
  logic [NS*AW-1:0] barRegs = '0;
  logic [AW-1:0]  romReg = '0;
  logic           reqValid = 1'b0;
  logic           reqIsIo = 1'b0;
  logic [AW-1:0]  reqAddr = '0;
  logic [NR-1:0]  regionValid;
  logic [NR*AW-1:0] regionBase;
  logic           hitValid;
  logic [2:0]     hitIndex;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bar_region_decoder i_bar_region_decoder (
    .clk(clk), .rstN(rstN), .cmdReg(cmdReg), .barRegs(barRegs),
    .romReg(romReg), .reqValid(reqValid), .reqIsIo(reqIsIo),
    .reqAddr(reqAddr), .regionValid(regionValid), .regionBase(regionBase),
    .hitValid(hitValid), .hitIndex(hitIndex)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic setBar(input int idx, input logic [31:0] v);
    barRegs[idx*AW +: AW] = v;
  endtask

  // Baseline map: r0 io 16B, r1 mem 4K, r2 mem 1M, r3 io 256B, r4 absent, r5 mem 16B, rom 64K.
  task automatic loadMap();
    @(negedge clk);
    setBar(0, 32'h0000_C001);
    setBar(1, 32'hF000_0ABC);
    setBar(2, 32'h8010_0000);
    setBar(3, 32'h0000_D101);
    setBar(4, 32'h1234_5000);
    setBar(5, 32'h9000_0008);
    romReg = 32'hA000_0001;
    cmdReg = 16'h0003;
    #1;
  endtask

  task automatic lookup(input string tag, input logic isIo, input logic [31:0] a,
                        input logic expHit, input logic [2:0] expIdx);
    @(negedge clk);
    reqValid = 1'b1; reqIsIo = isIo; reqAddr = a;
    @(posedge clk); #1;
    check({tag, " hitValid"}, {31'b0, hitValid}, {31'b0, expHit});
    check({tag, " hitIndex"}, {29'b0, hitIndex}, {29'b0, expIdx});
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    reqValid = 1'b1; reqIsIo = 1'b1; reqAddr = 32'h0000_C000;
    @(posedge clk); #1;
    check("R10 hitValid in reset", {31'b0, hitValid}, 32'd0);
    check("R10 hitIndex in reset", {29'b0, hitIndex}, 32'd0);
    @(negedge clk);
    reqValid = 1'b0;
    rstN = 1'b1;
  endtask

  task automatic t_cmd_gating();
    loadMap();
    cmdReg = 16'h0000; #1;
    check("R1 cmd=0 valid", {25'b0, regionValid}, 32'h00);
    cmdReg = 16'h0001; #1;
    check("R1 io only valid", {25'b0, regionValid}, 32'h09);
    cmdReg = 16'h0002; #1;
    check("R1 mem only valid", {25'b0, regionValid}, 32'h66);
    cmdReg = 16'h0003; #1;
    check("R1 both valid", {25'b0, regionValid}, 32'h6F);
  endtask

  task automatic t_bases();
    loadMap();
    check("R2 base r0", regionBase[0*AW +: AW], 32'h0000_C000);
    check("R2 base r1", regionBase[1*AW +: AW], 32'hF000_0000);
    check("R2 base r2", regionBase[2*AW +: AW], 32'h8010_0000);
    check("R2 base r3", regionBase[3*AW +: AW], 32'h0000_D100);
    check("R2 base r5", regionBase[5*AW +: AW], 32'h9000_0000);
    check("R2 base rom", regionBase[6*AW +: AW], 32'hA000_0000);
  endtask

  task automatic t_io_rules();
    loadMap();
    setBar(0, 32'h0000_0001); #1;
    check("R3 io zero base", {31'b0, regionValid[0]}, 32'd0);
    setBar(0, 32'h0000_FFF1); #1;
    check("R3 io end 0xFFFF ok", {31'b0, regionValid[0]}, 32'd1);
    setBar(3, 32'h0000_FF01); #1;
    check("R3 io 256B top ok", {31'b0, regionValid[3]}, 32'd1);
    setBar(3, 32'h0001_0001); #1;
    check("R3 io past 64K", {31'b0, regionValid[3]}, 32'd0);
    setBar(3, 32'hFFFF_FF01); #1;
    check("R3 io at top of space", {31'b0, regionValid[3]}, 32'd0);
  endtask

  task automatic t_mem_rules();
    loadMap();
    setBar(1, 32'hFFFF_F000); #1;
    check("R4 mem end all ones", {31'b0, regionValid[1]}, 32'd0);
    setBar(1, 32'hFFFF_E000); #1;
    check("R4 mem below top ok", {31'b0, regionValid[1]}, 32'd1);
    setBar(1, 32'h0000_0FFF); #1;
    check("R4 mem zero base", {31'b0, regionValid[1]}, 32'd0);
    setBar(5, 32'h0000_0010); #1;
    check("R4 mem low base ok", {31'b0, regionValid[5]}, 32'd1);
  endtask

  task automatic t_rom();
    loadMap();
    check("R5 rom enabled", {31'b0, regionValid[6]}, 32'd1);
    romReg = 32'hA000_0000; #1;
    check("R5 rom bit0 clear", {31'b0, regionValid[6]}, 32'd0);
    romReg = 32'hA000_0001; cmdReg = 16'h0001; #1;
    check("R5 rom mem off", {31'b0, regionValid[6]}, 32'd0);
    cmdReg = 16'h0003; #1;
    lookup("R5 rom hit", 1'b0, 32'hA000_FFFF, 1'b1, 3'd6);
    lookup("R5 rom as io misses", 1'b1, 32'h0000_A000, 1'b0, 3'd0);
  endtask

  task automatic t_absent();
    loadMap();
    check("R6 absent invalid", {31'b0, regionValid[4]}, 32'd0);
    lookup("R6 absent no hit", 1'b0, 32'h1234_5000, 1'b0, 3'd0);
  endtask

  task automatic t_hits();
    loadMap();
    lookup("R7 mem first byte", 1'b0, 32'h8010_0000, 1'b1, 3'd2);
    lookup("R7 mem last byte", 1'b0, 32'h801F_FFFF, 1'b1, 3'd2);
    lookup("R7 mem above end", 1'b0, 32'h8020_0000, 1'b0, 3'd0);
    lookup("R7 mem below base", 1'b0, 32'h800F_FFFF, 1'b0, 3'd0);
    lookup("R7 io last byte", 1'b1, 32'h0000_C00F, 1'b1, 3'd0);
    lookup("R7 io addr as mem", 1'b0, 32'h0000_C00F, 1'b0, 3'd0);
    lookup("R7 io r3", 1'b1, 32'h0000_D1FF, 1'b1, 3'd3);
    cmdReg = 16'h0002;
    lookup("R7 io disabled", 1'b1, 32'h0000_D100, 1'b0, 3'd0);
  endtask

  task automatic t_priority();
    loadMap();
    setBar(5, 32'hF000_0000);
    lookup("R8 r1 over r5", 1'b0, 32'hF000_0004, 1'b1, 3'd1);
    setBar(2, 32'h9000_0000);
    setBar(5, 32'h9000_0000);
    lookup("R8 r2 over r5", 1'b0, 32'h9000_0008, 1'b1, 3'd2);
    setBar(2, 32'h8010_0000);
    romReg = 32'h9000_0001;
    lookup("R8 r5 over rom", 1'b0, 32'h9000_0000, 1'b1, 3'd5);
  endtask

  task automatic t_idle();
    loadMap();
    lookup("R9 setup hit", 1'b0, 32'h8010_0000, 1'b1, 3'd2);
    @(negedge clk);
    reqValid = 1'b0; reqIsIo = 1'b0; reqAddr = 32'h8010_0000;
    @(posedge clk); #1;
    check("R9 idle hitValid", {31'b0, hitValid}, 32'd0);
    check("R9 idle hitIndex", {29'b0, hitIndex}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_cmd_gating();
    t_bases();
    t_io_rules();
    t_mem_rules();
    t_rom();
    t_absent();
    t_hits();
    t_priority();
    t_idle();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule